// File: doc/BRIEF.md
# Paged Program Counter Sequencer

This block generates the fetch address for a 4K-word program store in a small 4-bit processor core. The 12-bit address has two parts. The top bit is a page register. The lower 11 bits form a counter that advances once per executed instruction. Decoded control strobes from the instruction decoder redirect the counter: jumps, taken conditional branches, calls, returns, return-constant, computed table branches, interrupt entry and synchronous reset.

Only the 11-bit counter value moves to and from the subroutine stack. A call or interrupt entry presents the address to save on a registered push port, and a return takes the restored address from the stack. A return-constant operation also divides an 8-bit program-memory byte into two 4-bit registers. A later computed table branch can then use those two nibbles. The stack storage, the ALU and instruction decode are outside this block.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next state is `pc` = 0x000, `push_en` = 0 and `const_en` = 0, and `tbr_out` and `ac_out` are cleared to 0.
- R2: `step` with no other strobe adds one to `pc[10:0]` and leaves `pc[11]` unchanged. The value 0x7FF wraps to 0x000 inside the same page.
- R3: `jmp` loads `pc` with {`jmp_page`, `tgt`}. Only a jump, an interrupt entry or reset changes `pc[11]`.
- R4: `br_taken` loads `pc[10:0]` from `tgt` and keeps the page bit.
- R5: `call` loads `pc[10:0]` from `tgt` and keeps the page bit. In the next cycle it raises `push_en` with `push_addr` equal to the old `pc[10:0]` plus one, wrapping within 11 bits.
- R6: `ret` loads `pc[10:0]` from `ret_addr` and keeps the page bit.
- R7: Interrupt entry takes place when any bit of `irq_req` is set. Bit 0 (highest priority) vectors to 0x001, bit 1 to 0x002, bit 2 to 0x003 and bit 3 (lowest) to 0x004, and the page bit is cleared. `push_en` rises with `push_addr` equal to the old `pc[10:0]`, which is not incremented.
- R8: `tjmp` loads `pc` with {old `pc[11:8]`, `tbr_in`, `acc_in`}.
- R9: When strobes arrive together, the priority order is reset, interrupt, return (`ret` or `rtnw`), call, jump, branch, table jump, step. With no strobe at all, `pc` holds.
- R10: `rtnw` acts as a return. In the next cycle it also raises `const_en`, with `tbr_out` = `rom_byte[7:4]` and `ac_out` = `rom_byte[3:0]`. The two nibble outputs hold their values between loads. An interrupt in the same cycle suppresses the whole `rtnw` operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | Normal instruction completion, advance |
| jmp | input | 1 | Unconditional jump |
| jmp_page | input | 1 | Page bit loaded by a jump |
| br_taken | input | 1 | Taken conditional branch |
| call | input | 1 | Subroutine call |
| ret | input | 1 | Return |
| rtnw | input | 1 | Return with constant |
| tjmp | input | 1 | Computed table branch |
| irq_req | input | 4 | Interrupt requests, bit 0 highest priority |
| tgt | input | 11 | Immediate branch/jump/call target |
| ret_addr | input | 11 | Address popped from the stack |
| tbr_in | input | 4 | Table register nibble for table branch |
| acc_in | input | 4 | Accumulator nibble for table branch |
| rom_byte | input | 8 | Constant byte for return-constant |
| pc | output | 12 | Current fetch address |
| push_en | output | 1 | Push strobe to the stack |
| push_addr | output | 11 | Address to push |
| const_en | output | 1 | Constant nibbles valid |
| tbr_out | output | 4 | High nibble of the constant |
| ac_out | output | 4 | Low nibble of the constant |

## Verification
A corrupted page bit shows up on `pc[11]` one cycle after the faulty update, and it stays wrong until the next jump or vector entry. A wrong priority choice produces a wrong `pc` on the very next cycle. A wrong selection also produces a missing or spurious `push_en` in the same cycle, so a misordered strobe set is seen after one edge. Counter carry faults become visible only at the 0x7FF boundary, so the stimulus crosses that boundary in both pages.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  parameter int CNT_W  = 11;
  parameter int NIB_W  = 4;
  parameter int NUM_SRC = 4;
  parameter int ADDR_W = CNT_W + 1;

  typedef enum logic [2:0] {
    SEL_HOLD, SEL_INC, SEL_TJMP, SEL_BR, SEL_JMP, SEL_CALL, SEL_RET, SEL_VEC
  } sel_t;
endpackage

// File: rtl/pcseq_vec_enc.sv
module pcseq_vec_enc #(
  parameter int NUM_SRC = 4,
  parameter int CNT_W   = 11
) (
  input  logic [NUM_SRC-1:0] req,
  output logic               any,
  output logic [CNT_W-1:0]   vec
);
  always_comb begin
    any = |req;
    vec = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i]) vec = CNT_W'(i + 1);
    end
  end
endmodule

// File: rtl/pcseq_sel.sv
module pcseq_sel
  import pcseq_pkg::*;
(
  input  logic irq_any,
  input  logic ret_any,
  input  logic call,
  input  logic jmp,
  input  logic br_taken,
  input  logic tjmp,
  input  logic step,
  output sel_t sel
);
  always_comb begin
    if (irq_any)       sel = SEL_VEC;
    else if (ret_any)  sel = SEL_RET;
    else if (call)     sel = SEL_CALL;
    else if (jmp)      sel = SEL_JMP;
    else if (br_taken) sel = SEL_BR;
    else if (tjmp)     sel = SEL_TJMP;
    else if (step)     sel = SEL_INC;
    else               sel = SEL_HOLD;
  end
endmodule

// File: rtl/pcseq_regs.sv
module pcseq_regs
  import pcseq_pkg::*;
#(
  parameter int CNT_W = 11,
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  sel_t             sel,
  input  logic             jpage,
  input  logic [CNT_W-1:0] tgt,
  input  logic [CNT_W-1:0] ret_addr,
  input  logic [CNT_W-1:0] vec,
  input  logic [NIB_W-1:0] tbr,
  input  logic [NIB_W-1:0] acc,
  output logic             page_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             push_en,
  output logic [CNT_W-1:0] push_addr
);
  localparam int OFF_W = 2 * NIB_W;

  logic [CNT_W-1:0] cnt_inc, cnt_nxt;
  logic             page_nxt;

  assign cnt_inc = cnt_q + CNT_W'(1);

  always_comb begin
    cnt_nxt  = cnt_q;
    page_nxt = page_q;
    case (sel)
      SEL_INC:  cnt_nxt = cnt_inc;
      SEL_TJMP: cnt_nxt = {cnt_q[CNT_W-1:OFF_W], tbr, acc};
      SEL_BR:   cnt_nxt = tgt;
      SEL_JMP: begin
        cnt_nxt  = tgt;
        page_nxt = jpage;
      end
      SEL_CALL: cnt_nxt = tgt;
      SEL_RET:  cnt_nxt = ret_addr;
      SEL_VEC: begin
        cnt_nxt  = vec;
        page_nxt = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q    <= 1'b0;
      cnt_q     <= '0;
      push_en   <= 1'b0;
      push_addr <= '0;
    end else begin
      page_q  <= page_nxt;
      cnt_q   <= cnt_nxt;
      push_en <= (sel == SEL_CALL) || (sel == SEL_VEC);
      if (sel == SEL_CALL)     push_addr <= cnt_inc;
      else if (sel == SEL_VEC) push_addr <= cnt_q;
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (!page_q && cnt_q == '0 && !push_en));  // R1
  AST_INC_WRAP: assert property (@(posedge clk) disable iff (rst)
    sel == SEL_INC |=> (cnt_q == CNT_W'($past(cnt_q) + 1) && page_q == $past(page_q)));  // R2
  AST_PAGE_ONLY_JUMP: assert property (@(posedge clk) disable iff (rst)
    (sel != SEL_JMP && sel != SEL_VEC) |=> $stable(page_q));  // R3
  AST_BRANCH_LOAD: assert property (@(posedge clk) disable iff (rst)
    sel == SEL_BR |=> cnt_q == $past(tgt));  // R4
  AST_CALL_PUSH: assert property (@(posedge clk) disable iff (rst)
    sel == SEL_CALL |=> (push_en && push_addr == CNT_W'($past(cnt_q) + 1)));  // R5
  AST_TJMP_JOIN: assert property (@(posedge clk) disable iff (rst)
    sel == SEL_TJMP |=> (cnt_q[OFF_W-1:0] == {$past(tbr), $past(acc)}
                        && cnt_q[CNT_W-1:OFF_W] == $past(cnt_q[CNT_W-1:OFF_W])));  // R8
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcseq_pkg::*;
#(
  parameter int CNT_W   = pcseq_pkg::CNT_W,
  parameter int NIB_W   = pcseq_pkg::NIB_W,
  parameter int NUM_SRC = pcseq_pkg::NUM_SRC
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 step,
  input  logic                 jmp,
  input  logic                 jmp_page,
  input  logic                 br_taken,
  input  logic                 call,
  input  logic                 ret,
  input  logic                 rtnw,
  input  logic                 tjmp,
  input  logic [NUM_SRC-1:0]   irq_req,
  input  logic [CNT_W-1:0]     tgt,
  input  logic [CNT_W-1:0]     ret_addr,
  input  logic [NIB_W-1:0]     tbr_in,
  input  logic [NIB_W-1:0]     acc_in,
  input  logic [2*NIB_W-1:0]   rom_byte,
  output logic [CNT_W:0]       pc,
  output logic                 push_en,
  output logic [CNT_W-1:0]     push_addr,
  output logic                 const_en,
  output logic [NIB_W-1:0]     tbr_out,
  output logic [NIB_W-1:0]     ac_out
);
  localparam int ADDR_W = CNT_W + 1;

  logic             irq_any;
  logic [CNT_W-1:0] vec;
  sel_t             sel;
  logic             page_q;
  logic [CNT_W-1:0] cnt_q;

  pcseq_vec_enc #(.NUM_SRC(NUM_SRC), .CNT_W(CNT_W)) u_vec (
    .req(irq_req), .any(irq_any), .vec(vec)
  );

  pcseq_sel u_sel (
    .irq_any(irq_any), .ret_any(ret | rtnw), .call(call), .jmp(jmp),
    .br_taken(br_taken), .tjmp(tjmp), .step(step), .sel(sel)
  );

  pcseq_regs #(.CNT_W(CNT_W), .NIB_W(NIB_W)) u_regs (
    .clk(clk), .rst(rst), .sel(sel), .jpage(jmp_page), .tgt(tgt),
    .ret_addr(ret_addr), .vec(vec), .tbr(tbr_in), .acc(acc_in),
    .page_q(page_q), .cnt_q(cnt_q), .push_en(push_en), .push_addr(push_addr)
  );

  assign pc = {page_q, cnt_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      const_en <= 1'b0;
      tbr_out  <= '0;
      ac_out   <= '0;
    end else begin
      const_en <= rtnw && !irq_any;
      if (rtnw && !irq_any) begin
        tbr_out <= rom_byte[2*NIB_W-1:NIB_W];
        ac_out  <= rom_byte[NIB_W-1:0];
      end
    end
  end

  AST_RET_LOAD: assert property (@(posedge clk) disable iff (rst)
    (ret && !(|irq_req)) |=> (pc[CNT_W-1:0] == $past(ret_addr) && pc[CNT_W] == $past(pc[CNT_W])));  // R6
  AST_VEC_TOP: assert property (@(posedge clk) disable iff (rst)
    irq_req[0] |=> (pc == ADDR_W'(1) && push_en));  // R7
  AST_CALL_OVER_JMP: assert property (@(posedge clk) disable iff (rst)
    (call && jmp && !(|irq_req) && !ret && !rtnw) |=> push_en);  // R9
  AST_CONST_SPLIT: assert property (@(posedge clk) disable iff (rst)
    (rtnw && !(|irq_req)) |=> (const_en && {tbr_out, ac_out} == $past(rom_byte)));  // R10
endmodule

// File: tb/test_pc_sequencer.sv
module test_pc_sequencer;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, step, jmp, jmp_page, br_taken, call, ret, rtnw, tjmp;
  logic [3:0] irq_req;
  logic [10:0] tgt, ret_addr;
  logic [3:0] tbr_in, acc_in;
  logic [7:0] rom_byte;
  logic [11:0] pc;
  logic push_en, const_en;
  logic [10:0] push_addr;
  logic [3:0] tbr_out, ac_out;

  pc_sequencer i_pc_sequencer (
    .clk(clk), .rst(rst), .step(step), .jmp(jmp), .jmp_page(jmp_page),
    .br_taken(br_taken), .call(call), .ret(ret), .rtnw(rtnw), .tjmp(tjmp),
    .irq_req(irq_req), .tgt(tgt), .ret_addr(ret_addr), .tbr_in(tbr_in),
    .acc_in(acc_in), .rom_byte(rom_byte), .pc(pc), .push_en(push_en),
    .push_addr(push_addr), .const_en(const_en), .tbr_out(tbr_out), .ac_out(ac_out)
  );

  typedef struct {
    logic [11:0] pc;
    logic        pe;
    logic [10:0] pa;
    logic        ce;
    logic [3:0]  tb;
    logic [3:0]  ac;
    string       tag;
  } exp_t;

  exp_t q[$];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  // stimulus staging
  logic s_rst, s_step, s_jmp, s_jpage, s_br, s_call, s_ret, s_rtnw, s_tjmp;
  logic [3:0] s_irq, s_tbr, s_acc;
  logic [10:0] s_tgt, s_raddr;
  logic [7:0] s_rom;

  // reference model state
  logic [11:0] m_pc = '0;
  logic [10:0] m_pa = '0;
  logic [3:0]  m_tb = '0, m_ac = '0;

  task automatic clear_stim();
    s_rst = 0; s_step = 0; s_jmp = 0; s_jpage = 0; s_br = 0; s_call = 0;
    s_ret = 0; s_rtnw = 0; s_tjmp = 0; s_irq = '0; s_tbr = '0; s_acc = '0;
    s_tgt = '0; s_raddr = '0; s_rom = '0;
  endtask

  task automatic apply(input string tag);
    exp_t e;
    logic [11:0] old;
    @(negedge clk);
    rst = s_rst; step = s_step; jmp = s_jmp; jmp_page = s_jpage; br_taken = s_br;
    call = s_call; ret = s_ret; rtnw = s_rtnw; tjmp = s_tjmp; irq_req = s_irq;
    tgt = s_tgt; ret_addr = s_raddr; tbr_in = s_tbr; acc_in = s_acc; rom_byte = s_rom;
    old = m_pc;
    e.pe = 0; e.ce = 0;
    if (s_rst) begin
      m_pc = '0; m_pa = '0; m_tb = '0; m_ac = '0;
    end else if (|s_irq) begin
      if (s_irq[0]) m_pc = 12'h001;
      else if (s_irq[1]) m_pc = 12'h002;
      else if (s_irq[2]) m_pc = 12'h003;
      else m_pc = 12'h004;
      e.pe = 1; m_pa = old[10:0];
    end else if (s_ret || s_rtnw) begin
      m_pc = {old[11], s_raddr};
      if (s_rtnw) begin
        e.ce = 1; m_tb = s_rom[7:4]; m_ac = s_rom[3:0];
      end
    end else if (s_call) begin
      m_pc = {old[11], s_tgt}; e.pe = 1; m_pa = old[10:0] + 11'd1;
    end else if (s_jmp) m_pc = {s_jpage, s_tgt};
    else if (s_br) m_pc = {old[11], s_tgt};
    else if (s_tjmp) m_pc = {old[11:8], s_tbr, s_acc};
    else if (s_step) m_pc = {old[11], old[10:0] + 11'd1};
    e.pc = m_pc; e.pa = m_pa; e.tb = m_tb; e.ac = m_ac; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [11:0] act, input logic [11:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(pc === e.pc, e.tag, "pc", pc, e.pc);
      chk(push_en === e.pe, e.tag, "push_en", 12'(push_en), 12'(e.pe));
      if (e.pe) chk(push_addr === e.pa, e.tag, "push_addr", 12'(push_addr), 12'(e.pa));
      chk(const_en === e.ce, e.tag, "const_en", 12'(const_en), 12'(e.ce));
      chk({tbr_out, ac_out} === {e.tb, e.ac}, e.tag, "const", 12'({tbr_out, ac_out}), 12'({e.tb, e.ac}));
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #40000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired, actual=hung expected=finished");
    finish_run();
  end

  initial begin
    clear_stim();
    rst = 1; step = 0; jmp = 0; jmp_page = 0; br_taken = 0; call = 0; ret = 0;
    rtnw = 0; tjmp = 0; irq_req = '0; tgt = '0; ret_addr = '0; tbr_in = '0;
    acc_in = '0; rom_byte = '0;
    s_rst = 1; apply("R1"); apply("R1");
    clear_stim();
    s_step = 1; repeat (3) apply("R2");                       // 0x003
    clear_stim(); s_jmp = 1; s_jpage = 1; s_tgt = 11'h7FE; apply("R3"); // 0xFFE
    clear_stim(); s_step = 1; apply("R2"); apply("R2");       // 0xFFF then wrap to 0x800
    clear_stim(); s_call = 1; s_tgt = 11'h123; apply("R5");   // 0x923, push 0x001
    clear_stim(); s_br = 1; s_tgt = 11'h055; apply("R4");     // 0x855
    clear_stim(); s_ret = 1; s_raddr = 11'h001; apply("R6");  // 0x801
    clear_stim(); s_tjmp = 1; s_tbr = 4'hA; s_acc = 4'h5; apply("R8"); // 0x8A5
    clear_stim(); s_irq = 4'b1100; apply("R7");               // 0x003, push 0x0A5
    clear_stim(); s_irq = 4'b1000; apply("R7");               // 0x004
    clear_stim(); s_irq = 4'b1111; apply("R7");               // 0x001
    clear_stim(); s_irq = 4'b0010; apply("R7");               // 0x002
    clear_stim(); s_rtnw = 1; s_raddr = 11'h234; s_rom = 8'hC3; apply("R10");
    clear_stim(); s_step = 1; apply("R10");                   // nibbles hold
    clear_stim(); s_call = 1; s_jmp = 1; s_jpage = 1; s_tgt = 11'h400; apply("R9");
    clear_stim(); s_jmp = 1; s_jpage = 1; s_br = 1; s_tjmp = 1; s_step = 1;
    s_tgt = 11'h111; apply("R9");
    clear_stim(); s_tjmp = 1; s_step = 1; s_tbr = 4'h3; s_acc = 4'hC; apply("R9");
    clear_stim(); s_irq = 4'b0100; s_ret = 1; s_rtnw = 1; s_rom = 8'h5A; apply("R9");
    clear_stim(); apply("R9");                                // hold
    clear_stim(); s_rst = 1; s_irq = 4'b0001; s_call = 1; apply("R1");
    clear_stim(); s_jmp = 1; s_jpage = 0; s_tgt = 11'h7FF; apply("R3");
    clear_stim(); s_step = 1; apply("R2");                    // wrap to 0x000
    clear_stim(); s_call = 1; s_tgt = 11'h7FF; apply("R5");
    clear_stim(); s_ret = 1; s_raddr = 11'h000; apply("R6");
    clear_stim(); apply("R9");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule